// File: doc/BRIEF.md
# Paged EEPROM Command Sequencer

This block sits behind a byte-level serial receiver and interprets the byte stream a host sends to a small non-volatile store. The store holds 256 bytes organised as 64 pages of four bytes. A session begins when the select input rises and ends when it falls. Each received byte is presented with a one-cycle strobe. For every received byte, the block presents a reply byte for the next byte slot.

A read session sends the read opcode and then a page byte, and gets the four page bytes back in order. A write session sends an enable opcode, a write opcode, a page byte, four data bytes and a disable opcode. The four data bytes are held in a buffer. They reach the array only when the complete and valid sequence has arrived, under a write-enable latch. Dropping select at any point abandons the session, and the next session decodes from its first byte. The array is modelled with registers. It resets to the erased value 0xFF, and the serial-number and checksum area at the top of the map is plain storage.

Top module: `eeseq_top`

## Requirements
- R1: After reset every array byte reads 0xFF and reply_o is 0xFF.
- R2: A read session (first byte 0x03, then a page byte) presents array bytes page*4+0, +1, +2, +3 on reply_o, one after the page byte and one after each of the next three strobes. After the fourth returned byte, reply_o goes back to 0xFF.
- R3: The sequence 0x06, 0x02, page byte, d0..d3, 0x04 writes dk to array offset page*4+k, for k from 0 to 3.
- R4: The page number is bits 7..2 of the page byte, and bits 1..0 of that byte are ignored.
- R5: Deasserting sel_i before the session completes aborts it. A partly sent write leaves the page unchanged, and the next session decodes from its first byte.
- R6: A write opcode 0x02 sent without a preceding 0x06 in the same session is ignored, and the page is not changed.
- R7: A first byte other than 0x03 or 0x06 makes the block ignore the rest of the session: nothing is written and reply_o stays 0xFF.
- R8: After 0x06, a second byte other than 0x02, or a final byte other than 0x04, leaves the page unchanged.
- R9: Bytes received while read data is being returned are ignored. They neither write the array nor alter the returned sequence.
- R10: reply_o is 0xFF throughout a write session, and also whenever sel_i is low.
- R11: reply_o takes the value for the next slot in the clock cycle after the strobe of the byte that determines it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Session active; a falling edge ends or aborts the session |
| byte_vld_i | input | 1 | One-cycle strobe marking a received byte |
| byte_i | input | 8 | Received byte |
| reply_o | output | 8 | Byte to return in the next byte slot |

## Verification
Each strobe is registered on one clock edge, so the reply it selects is due in the cycle after the strobe. The bench drives each strobe for a single cycle starting at a falling edge, and it reads reply_o at the following falling edge. A committed write appears to the session that comes after it, so every write, ignored write or aborted write is judged by a later read session of the same page, checked against a bench copy of the array. Random sessions cover every decode path, and directed cases cover page 0, page 63, nonzero bits in the two low bits of the page byte, and aborts at each byte position.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_W_INSN, ST_W_PAGE, ST_W_DATA, ST_W_END, ST_R_PAGE, ST_R_DATA, ST_DONE
  } seq_st_e;
endpackage

// File: rtl/eeseq_decode.sv
module eeseq_decode
  import eeseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int PAGES = 64,
  parameter int PAGE_BYTES = 4,
  localparam int PG_W = $clog2(PAGES),
  localparam int LN_W = $clog2(PAGE_BYTES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_i,
  input  logic                     byte_vld_i,
  input  logic [DW-1:0]            byte_i,
  output logic                     commit_o,
  output logic                     rd_en_o,
  output logic [PG_W-1:0]          pg_o,
  output logic [LN_W-1:0]          lane_o,
  output logic [PAGE_BYTES*DW-1:0] wdata_o
);
  localparam logic [LN_W-1:0] LAST_LANE = LN_W'(PAGE_BYTES - 1);

  seq_st_e st_q, st_d;
  logic [LN_W-1:0] idx_q, idx_d;
  logic [PG_W-1:0] pg_q, pg_d;
  logic wen_q, wen_d;
  logic [PAGE_BYTES*DW-1:0] wbuf_q, wbuf_d;

  always_comb begin
    st_d = st_q;
    idx_d = idx_q;
    pg_d = pg_q;
    wen_d = wen_q;
    wbuf_d = wbuf_q;
    if (!sel_i) begin
      st_d = ST_IDLE;
      idx_d = '0;
      wen_d = 1'b0;
    end else if (byte_vld_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (byte_i == OP_READ) st_d = ST_R_PAGE;
          else if (byte_i == OP_WREN) begin
            st_d = ST_W_INSN;
            wen_d = 1'b1;
          end else st_d = ST_DONE;
        end
        ST_W_INSN: begin
          if (byte_i == OP_WRITE && wen_q) st_d = ST_W_PAGE;
          else begin
            st_d = ST_DONE;
            wen_d = 1'b0;
          end
        end
        ST_W_PAGE, ST_R_PAGE: begin
          pg_d = byte_i[DW-1 -: PG_W];  // low bits of page byte dropped
          idx_d = '0;
          st_d = (st_q == ST_W_PAGE) ? ST_W_DATA : ST_R_DATA;
        end
        ST_W_DATA: begin
          wbuf_d[idx_q*DW +: DW] = byte_i;
          if (idx_q == LAST_LANE) st_d = ST_W_END;
          else idx_d = idx_q + 1'b1;
        end
        ST_W_END: begin
          st_d = ST_DONE;
          wen_d = 1'b0;
        end
        ST_R_DATA: begin
          if (idx_q == LAST_LANE) st_d = ST_DONE;
          else idx_d = idx_q + 1'b1;
        end
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      idx_q <= '0;
      pg_q <= '0;
      wen_q <= 1'b0;
      wbuf_q <= '0;
    end else begin
      st_q <= st_d;
      idx_q <= idx_d;
      pg_q <= pg_d;
      wen_q <= wen_d;
      wbuf_q <= wbuf_d;
    end
  end

  assign commit_o = sel_i && byte_vld_i && st_q == ST_W_END && byte_i == OP_WRDI && wen_q;
  assign rd_en_o = st_q == ST_R_DATA;
  assign pg_o = pg_q;
  assign lane_o = idx_q;
  assign wdata_o = wbuf_q;

  assert_commit_needs_wen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> wen_q);
  assert_wen_from_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wen_q) |-> $past(byte_i) == OP_WREN && $past(byte_vld_i));
  assert_abort_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> st_q == ST_IDLE && !wen_q);
  assert_read_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && !byte_vld_i && sel_i |=> $stable(idx_q) && $stable(pg_q));
endmodule

// File: rtl/eeseq_store.sv
module eeseq_store
  import eeseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int PAGES = 64,
  parameter int PAGE_BYTES = 4,
  localparam int PG_W = $clog2(PAGES),
  localparam int LN_W = $clog2(PAGE_BYTES),
  localparam int DEPTH = PAGES * PAGE_BYTES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PG_W-1:0]          pg_i,
  input  logic [LN_W-1:0]          lane_i,
  input  logic [PAGE_BYTES*DW-1:0] wdata_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_lane
    for (genvar p = 0; p < PAGES; p++) begin : g_page
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[p*PAGE_BYTES+k] <= DW'(IDLE_BYTE);
        else if (we_i && pg_i == PG_W'(p)) mem_q[p*PAGE_BYTES+k] <= wdata_i[k*DW +: DW];
      end
    end
  end

  assign rdata_o = mem_q[{pg_i, lane_i}];

  assert_commit_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[{$past(pg_i), LN_W'(0)}] == $past(wdata_i[DW-1:0]));
endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int PAGES = 64,
  parameter int PAGE_BYTES = 4,
  localparam int PG_W = $clog2(PAGES),
  localparam int LN_W = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] reply_o
);
  logic commit, rd_en;
  logic [PG_W-1:0] pg;
  logic [LN_W-1:0] lane;
  logic [PAGE_BYTES*DW-1:0] wdata;
  logic [DW-1:0] rdata;

  eeseq_decode #(.DW(DW), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_dec (
    .clk_i, .rst_ni, .sel_i, .byte_vld_i, .byte_i,
    .commit_o(commit), .rd_en_o(rd_en), .pg_o(pg), .lane_o(lane), .wdata_o(wdata)
  );

  eeseq_store #(.DW(DW), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk_i, .rst_ni, .we_i(commit), .pg_i(pg), .lane_i(lane),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  assign reply_o = rd_en ? rdata : DW'(IDLE_BYTE);

  assert_idle_reply_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> reply_o == DW'(IDLE_BYTE));
  assert_no_read_write_mix_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> !rd_en);
endmodule

// File: tb/sim_eeseq_top.sv
module sim_eeseq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic vld = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] reply;
  logic [7:0] ref_mem [256];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  eeseq_top u0 (.clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .byte_vld_i(vld),
                .byte_i(din), .reply_o(reply));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] page_byte(input int pg, input logic [1:0] junk);
    return {pg[5:0], junk};
  endfunction

  // Sends one byte; returns the reply presented for the next slot
  task automatic send(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    din = b;
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    r = reply;
  endtask

  task automatic open_s();
    @(negedge clk);
    sel = 1'b1;
  endtask

  task automatic close_s(input string req);
    @(negedge clk);
    sel = 1'b0;
    @(negedge clk);
    check(req, reply, 8'hFF);
  endtask

  task automatic read_chk(input int pg, input string req);
    logic [7:0] r;
    open_s();
    send(8'h03, r);
    check(req, r, 8'hFF);
    send(page_byte(pg, 2'($urandom)), r);
    for (int k = 0; k < 4; k++) begin
      check(req, r, ref_mem[pg*4+k]);
      send(8'($urandom), r);  // host bytes here are ignored (R9)
    end
    check("R2", r, 8'hFF);
    close_s("R10");
  endtask

  // kind: 0 good, 1 no enable, 2 bad first, 3 bad insn, 4 bad end, 5 abort
  task automatic write_s(input int pg, input logic [31:0] d, input int kind, input int cut);
    logic [7:0] seq [8];
    logic [7:0] r;
    int n;
    seq[0] = 8'h06; seq[1] = 8'h02; seq[2] = page_byte(pg, 2'($urandom));
    for (int k = 0; k < 4; k++) seq[3+k] = d[k*8 +: 8];
    seq[7] = 8'h04;
    n = 8;
    if (kind == 1) seq[0] = 8'h02;
    if (kind == 2) seq[0] = (8'($urandom) | 8'h10);
    if (kind == 3) seq[1] = 8'h06;
    if (kind == 4) seq[7] = 8'h05;
    if (kind == 5) n = cut;
    open_s();
    for (int i = 0; i < n; i++) begin
      send(seq[i], r);
      check("R10", r, 8'hFF);
    end
    close_s("R5");
    if (kind == 0)
      for (int k = 0; k < 4; k++) ref_mem[pg*4+k] = d[k*8 +: 8];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1", reply, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", reply, 8'hFF);
    read_chk(0, "R1");
    read_chk(63, "R1");
    // R3/R4 directed: page 0 and 63, junk low bits
    write_s(0, 32'h44332211, 0, 0);
    read_chk(0, "R3");
    write_s(63, 32'hDDCCBBAA, 0, 0);
    read_chk(63, "R4");
    // R11: reply for a page is due the cycle right after the page strobe
    open_s();
    send(8'h03, r);
    send(page_byte(63, 2'b11), r);
    check("R11", r, 8'hAA);
    close_s("R5");
    // R5: abort a read mid-data, then restart cleanly
    open_s();
    send(8'h03, r);
    send(page_byte(0, 2'b00), r);
    send(8'h03, r);
    check("R5", r, 8'h22);
    @(negedge clk); sel = 1'b0; @(negedge clk);
    read_chk(0, "R5");
    // aborts at every position of a write
    for (int c = 1; c < 8; c++) begin
      write_s(5, 32'h0BADF00D, 5, c);
      read_chk(5, "R5");
    end
    write_s(9, 32'h12345678, 1, 0); read_chk(9, "R6");
    write_s(9, 32'h12345678, 2, 0); read_chk(9, "R7");
    write_s(9, 32'h12345678, 3, 0); read_chk(9, "R8");
    write_s(9, 32'h12345678, 4, 0); read_chk(9, "R8");
    // random mix
    for (int it = 0; it < 250; it++) begin
      int pg, kind;
      pg = int'($urandom_range(63, 0));
      kind = (($urandom_range(2, 0)) == 0) ? int'($urandom_range(5, 1)) : 0;
      write_s(pg, $urandom, kind, int'($urandom_range(7, 1)));
      case (kind)
        0: read_chk(pg, "R3");
        1: read_chk(pg, "R6");
        2: read_chk(pg, "R7");
        3, 4: read_chk(pg, "R8");
        default: read_chk(pg, "R5");
      endcase
    end
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule